// File: doc/BRIEF.md
# Error-Correcting RAM Wrapper with Check-Bit Access

This block sits between a simple request/response bus and a word-wide storage array and guards every stored 64-bit word with eight check bits of an extended Hamming code. Check bits are always generated on a data write. The reporting switch only decides whether error events reach the response flags, the status register and the interrupt. The code is offset by a constant so that a cleared all-zero word carries a check byte of 0x0C. An array that powers up with zero data and zero check bits therefore shows up as a double-bit error once reporting is on.

A second address window exposes the stored check bytes, so software can overwrite them on purpose and inject single-bit or double-bit faults. A control register turns that window on and sets the interrupt enable. The reporting switch in the same register changes only when one of two 4-bit key values is written. The request address carries a 2-bit region select above the word index: 00 selects data words, 01 the check-byte window, 10 the registers (index bit 0 = 0 is control, 1 is status), and 11 reads as zero and ignores writes.

Top module: `secded_ram_wrap`

## Requirements
- R1: A write to a data word stores that word's check byte whether reporting is on or off. A word written while reporting is off reads back clean once reporting is on, and its check window holds the encoded value.
- R2: A word written as all zeros holds check byte 0x0C.
- R3: Control bits [3:0] are a key. 0xA turns reporting on, 0x5 turns it off, and any other value leaves it as it was. Bit 4 is the check-window write enable and bit 5 is the interrupt enable; both are written on every control write. A control read returns 0xA or 0x5 in bits [3:0] for on or off, with bits 4 and 5 as written. After reset, reporting is off and both enables are 0.
- R4: With reporting off, a mismatching word raises neither response flag, leaves the status register unchanged and keeps the interrupt low.
- R5: With reporting on, reading a word never written since reset gives a double-bit error.
- R6: A write to the check window changes the stored byte only when control bit 4 is 1. A read of the window returns the stored byte in bits [7:0] with zeros above, and raises no error flag.
- R7: One flipped bit (data, Hamming or overall parity bit) is corrected in the returned data whether or not reporting is on. With reporting on, the single-error response flag is raised.
- R8: Two flipped bits return the stored data unchanged and, with reporting on, raise the double-error response flag. The two flags are never both set.
- R9: The status register holds a single-error flag in bit 0, a double-error flag in bit 1 and the failing word index from bit 16 up. A reported event sets its flag and records the index. Writing 1 to a flag bit clears that flag and leaves the index.
- R10: The interrupt is high exactly when the interrupt enable is 1 and at least one status flag is set.
- R11: A read accepted on one clock edge has its response valid after that edge. The response is held unchanged while the response ready is low, and request ready stays low during that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W+2 | Region select (top two bits) and word index |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response consumed |
| rsp_rdata | output | 64 | Read data, corrected when a single error is found |
| rsp_sec | output | 1 | Single-bit error reported with this response |
| rsp_ded | output | 1 | Double-bit error reported with this response |
| irq | output | 1 | Error interrupt |

## Verification
The decoder is exercised with clean words (zero and mixed patterns), with a flipped Hamming bit, a flipped overall parity bit, a data bit flipped by writing a check byte that belongs to a neighbouring data value, and with two flipped bits in the check byte or in the data. The single-bit cases show that correction targets the right position: a data-bit fault must return the altered value, while a check-bit fault must return the original value. The double-bit cases show that the code classifies the error as uncorrectable rather than miscorrecting it. Running the same faults with reporting off shows that correction still happens while the flags, status and interrupt stay quiet. A never-written word shows that the 0x0C offset makes the cleared power-up content detectable.

// File: rtl/secded_pkg.sv
package secded_pkg;
  localparam int DATA_W = 64;
  localparam int CHK_W = 8;
  localparam int HAM_W = 7;
  localparam int TOP_POS = 71;
  localparam logic [CHK_W-1:0] ZERO_CHK = 8'h0C;
  localparam logic [3:0] KEY_ON = 4'hA;
  localparam logic [3:0] KEY_OFF = 4'h5;

  typedef enum logic [1:0] {
    RG_DATA = 2'b00,
    RG_CHK  = 2'b01,
    RG_REGS = 2'b10,
    RG_NONE = 2'b11
  } region_e;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              sec;
    logic              ded;
  } dec_t;

  // XOR of the code positions of all set data bits (positions skip powers of two)
  function automatic logic [HAM_W-1:0] ham_bits(input logic [DATA_W-1:0] d);
    logic [HAM_W-1:0] c;
    int n;
    c = '0;
    n = 0;
    for (int p = 3; p <= TOP_POS; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (d[n]) c = c ^ 7'(p);
        n++;
      end
    end
    return c;
  endfunction

  function automatic logic [CHK_W-1:0] encode(input logic [DATA_W-1:0] d);
    logic [HAM_W-1:0] c;
    c = ham_bits(d);
    return {(^d) ^ (^c), c} ^ ZERO_CHK;
  endfunction

  function automatic logic [DATA_W-1:0] flip_at(input logic [DATA_W-1:0] d,
                                                input logic [HAM_W-1:0] pos);
    logic [DATA_W-1:0] r;
    int n;
    r = d;
    n = 0;
    for (int p = 3; p <= TOP_POS; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (7'(p) == pos) r[n] = ~r[n];
        n++;
      end
    end
    return r;
  endfunction

  function automatic dec_t decode(input logic [DATA_W-1:0] d,
                                  input logic [CHK_W-1:0] stored);
    dec_t o;
    logic [CHK_W-1:0] raw;
    logic [HAM_W-1:0] syn;
    logic par_err;
    logic in_range;
    raw = stored ^ ZERO_CHK;
    syn = raw[HAM_W-1:0] ^ ham_bits(d);
    par_err = (^d) ^ (^raw);
    in_range = (syn <= 7'(TOP_POS));
    o.sec = par_err && in_range;
    o.ded = (!par_err && (syn != '0)) || (par_err && !in_range);
    o.data = (o.sec && syn != '0) ? flip_at(d, syn) : d;
    return o;
  endfunction
endpackage

// File: rtl/secded_store.sv
module secded_store #(
  parameter int ADDR_W = 6,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ADDR_W-1:0]             idx,
  input  logic                          wr_data,
  input  logic                          wr_chk,
  input  logic [secded_pkg::DATA_W-1:0] wdata,
  input  logic [secded_pkg::CHK_W-1:0]  wchk,
  output logic [secded_pkg::DATA_W-1:0] rdata,
  output logic [secded_pkg::CHK_W-1:0]  rchk
);
  logic [secded_pkg::DATA_W-1:0] dmem [DEPTH];
  logic [secded_pkg::CHK_W-1:0]  cmem [DEPTH];

  // Reset models power-up content: zero data with zero check bits (a mismatch)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        dmem[i] <= '0;
        cmem[i] <= '0;
      end
    end else begin
      if (wr_data) dmem[idx] <= wdata;
      if (wr_data || wr_chk) cmem[idx] <= wchk;
    end
  end

  assign rdata = dmem[idx];
  assign rchk  = cmem[idx];
endmodule

// File: rtl/secded_regs.sv
module secded_regs #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_stat,
  input  logic [5:0]        wbits,
  input  logic              ev_sec,
  input  logic              ev_ded,
  input  logic [ADDR_W-1:0] ev_idx,
  output logic              rep_en,
  output logic              chk_we,
  output logic              irq_en,
  output logic [63:0]       ctrl_rd,
  output logic [63:0]       stat_rd,
  output logic              irq
);
  import secded_pkg::*;

  logic              sec_f, ded_f;
  logic [ADDR_W-1:0] fail_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rep_en <= 1'b0;
      chk_we <= 1'b0;
      irq_en <= 1'b0;
    end else if (wr_ctrl) begin
      if (wbits[3:0] == KEY_ON) rep_en <= 1'b1;
      else if (wbits[3:0] == KEY_OFF) rep_en <= 1'b0;
      chk_we <= wbits[4];
      irq_en <= wbits[5];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_f    <= 1'b0;
      ded_f    <= 1'b0;
      fail_idx <= '0;
    end else begin
      if (ev_sec) sec_f <= 1'b1;
      else if (wr_stat && wbits[0]) sec_f <= 1'b0;
      if (ev_ded) ded_f <= 1'b1;
      else if (wr_stat && wbits[1]) ded_f <= 1'b0;
      if (ev_sec || ev_ded) fail_idx <= ev_idx;
    end
  end

  assign ctrl_rd = {58'b0, irq_en, chk_we, rep_en ? KEY_ON : KEY_OFF};
  assign stat_rd = {{(48 - ADDR_W){1'b0}}, fail_idx, 14'b0, ded_f, sec_f};
  assign irq     = irq_en && (sec_f || ded_f);
endmodule

// File: rtl/secded_ram_wrap.sv
module secded_ram_wrap #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W+1:0] req_addr,
  input  logic [63:0]       req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [63:0]       rsp_rdata,
  output logic              rsp_sec,
  output logic              rsp_ded,
  output logic              irq
);
  import secded_pkg::*;

  region_e           region;
  logic [ADDR_W-1:0] idx;
  logic              fire, wr_fire, rd_fire;
  logic              wr_data_en, wr_chk_en, wr_ctrl_en, wr_stat_en;
  logic              rd_data;
  logic              rep_en, chk_we, irq_en;
  logic [63:0]       ctrl_rd, stat_rd;
  logic [DATA_W-1:0] st_data;
  logic [CHK_W-1:0]  st_chk, w_chk;
  dec_t              dec;
  logic              ev_sec, ev_ded, ev_any;
  logic [63:0]       rd_word;

  assign region = region_e'(req_addr[ADDR_W+1:ADDR_W]);
  assign idx    = req_addr[ADDR_W-1:0];

  assign req_ready = !rsp_valid || rsp_ready;
  assign fire      = req_valid && req_ready;
  assign wr_fire   = fire && req_write;
  assign rd_fire   = fire && !req_write;

  assign wr_data_en = wr_fire && (region == RG_DATA);
  assign wr_chk_en  = wr_fire && (region == RG_CHK) && chk_we;
  assign wr_ctrl_en = wr_fire && (region == RG_REGS) && !idx[0];
  assign wr_stat_en = wr_fire && (region == RG_REGS) && idx[0];
  assign rd_data    = rd_fire && (region == RG_DATA);

  assign w_chk = wr_data_en ? encode(req_wdata) : req_wdata[CHK_W-1:0];

  secded_store #(.ADDR_W(ADDR_W)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .idx    (idx),
    .wr_data(wr_data_en),
    .wr_chk (wr_chk_en),
    .wdata  (req_wdata),
    .wchk   (w_chk),
    .rdata  (st_data),
    .rchk   (st_chk)
  );

  assign dec = decode(st_data, st_chk);

  assign ev_sec = rd_data && rep_en && dec.sec;
  assign ev_ded = rd_data && rep_en && dec.ded;
  assign ev_any = ev_sec || ev_ded;

  secded_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_ctrl(wr_ctrl_en),
    .wr_stat(wr_stat_en),
    .wbits  (req_wdata[5:0]),
    .ev_sec (ev_sec),
    .ev_ded (ev_ded),
    .ev_idx (idx),
    .rep_en (rep_en),
    .chk_we (chk_we),
    .irq_en (irq_en),
    .ctrl_rd(ctrl_rd),
    .stat_rd(stat_rd),
    .irq    (irq)
  );

  always_comb begin
    case (region)
      RG_DATA: rd_word = dec.data;
      RG_CHK:  rd_word = {{(64 - CHK_W){1'b0}}, st_chk};
      RG_REGS: rd_word = idx[0] ? stat_rd : ctrl_rd;
      default: rd_word = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_sec   <= 1'b0;
      rsp_ded   <= 1'b0;
    end else if (rd_fire) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd_word;
      rsp_sec   <= ev_sec;
      rsp_ded   <= ev_ded;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/secded_ram_wrap_chk.sv
module secded_ram_wrap_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [63:0] rsp_rdata,
  input logic        rsp_sec,
  input logic        rsp_ded,
  input logic        irq,
  input logic        rd_fire,
  input logic        rep_en,
  input logic        wr_ctrl_en,
  input logic        ev_any
);
  p_rsp_next_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> rsp_valid);

  p_rsp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  p_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  p_flags_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_sec && rsp_ded));

  p_quiet_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rd_fire) && !$past(rep_en)) |-> (!rsp_sec && !rsp_ded));

  p_key_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rep_en) || $fell(rep_en)) |-> $past(wr_ctrl_en));

  p_irq_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(ev_any) || $past(wr_ctrl_en)));
endmodule

bind secded_ram_wrap secded_ram_wrap_chk u_chk (.*);

// File: tb/secded_ram_wrap_bench.sv
module secded_ram_wrap_bench;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [AW+1:0] req_addr = '0;
  logic [63:0]   req_wdata = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b1;
  logic [63:0]   rsp_rdata;
  logic          rsp_sec, rsp_ded;
  logic          irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int posn [64];
  logic [63:0] rd_d;
  logic rd_s, rd_e;

  always #2 clk = ~clk;

  secded_ram_wrap #(.ADDR_W(AW)) u_secded_ram_wrap (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .rsp_sec(rsp_sec), .rsp_ded(rsp_ded), .irq(irq)
  );

  function automatic logic [AW+1:0] a_dat(input int i); return {2'b00, AW'(i)}; endfunction
  function automatic logic [AW+1:0] a_chk(input int i); return {2'b01, AW'(i)}; endfunction
  localparam logic [AW+1:0] A_CTRL = {2'b10, AW'(0)};
  localparam logic [AW+1:0] A_STAT = {2'b10, AW'(1)};

  // Independent encoder: per check bit, scan the data bits whose position has it
  function automatic logic [7:0] enc(input logic [63:0] d);
    logic [6:0] h;
    for (int j = 0; j < 7; j++) begin
      logic b;
      b = 1'b0;
      for (int i = 0; i < 64; i++) if (posn[i][j]) b = b ^ d[i];
      h[j] = b;
    end
    return {(^d) ^ (^h), h} ^ 8'h0C;
  endfunction

  function automatic logic [63:0] stat_val(input int a, input bit s, input bit e);
    return (64'(a) << 16) | (64'(e) << 1) | 64'(s);
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW+1:0] a, input logic [63:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [AW+1:0] a);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R11 response one cycle after accept", 64'(rsp_valid), 64'd1);
    rd_d = rsp_rdata; rd_s = rsp_sec; rd_e = rsp_ded;
  endtask

  task automatic expect_rd(input string tag, input logic [AW+1:0] a,
                           input logic [63:0] d, input bit s, input bit e);
    rd(a);
    chk({tag, " data"}, rd_d, d);
    chk({tag, " sec"}, 64'(rd_s), 64'(s));
    chk({tag, " ded"}, 64'(rd_e), 64'(e));
  endtask

  task automatic t_reset();
    chk("R11 ready after reset", 64'(req_ready), 64'd1);
    chk("R10 irq low after reset", 64'(irq), 64'd0);
    rd(A_CTRL); chk("R3 control reset value", rd_d, 64'h5);
    rd(A_STAT); chk("R9 status reset value", rd_d, 64'h0);
  endtask

  task automatic t_powerup();
    wr(A_CTRL, 64'h0A);
    expect_rd("R5 never-written word", a_dat(3), 64'h0, 1'b0, 1'b1);
    rd(A_STAT); chk("R9 status after double event", rd_d, stat_val(3, 0, 1));
    wr(A_STAT, 64'h3);
    rd(A_STAT); chk("R9 write-one clear keeps index", rd_d, stat_val(3, 0, 0));
    rd(a_chk(3)); chk("R6 window read of power-up byte", rd_d, 64'h0);
  endtask

  task automatic t_zero();
    wr(a_dat(5), 64'h0);
    rd(a_chk(5)); chk("R2 zero word check byte", rd_d, 64'h0C);
    expect_rd("R2 zero word clean", a_dat(5), 64'h0, 1'b0, 1'b0);
  endtask

  task automatic t_write_off(input logic [63:0] p);
    wr(A_CTRL, 64'h05);
    wr(a_dat(7), p);
    wr(A_CTRL, 64'h0A);
    expect_rd("R1 written while off", a_dat(7), p, 1'b0, 1'b0);
    rd(a_chk(7)); chk("R1 stored check byte", rd_d, 64'(enc(p)));
  endtask

  task automatic t_keys();
    wr(A_CTRL, 64'h03); rd(A_CTRL); chk("R3 other key keeps on", rd_d, 64'h0A);
    wr(A_CTRL, 64'h05); rd(A_CTRL); chk("R3 off key", rd_d, 64'h05);
    wr(A_CTRL, 64'h0F); rd(A_CTRL); chk("R3 other key keeps off", rd_d, 64'h05);
    wr(A_CTRL, 64'h3C); rd(A_CTRL); chk("R3 enable bits written", rd_d, 64'h35);
    wr(A_CTRL, 64'h0A); rd(A_CTRL); chk("R3 on key", rd_d, 64'h0A);
  endtask

  task automatic t_guard(input logic [63:0] p);
    wr(a_chk(7), 64'hFF);
    rd(a_chk(7)); chk("R6 window write blocked", rd_d, 64'(enc(p)));
    chk("R6 window read no flag", 64'({rd_s, rd_e}), 64'd0);
  endtask

  task automatic t_single(input logic [63:0] p);
    logic [63:0] q;
    wr(A_CTRL, 64'h1A);
    wr(a_chk(7), 64'(enc(p) ^ 8'h01));
    rd(a_chk(7)); chk("R6 window write allowed", rd_d, 64'(enc(p) ^ 8'h01));
    expect_rd("R7 hamming bit flip", a_dat(7), p, 1'b1, 1'b0);
    rd(A_STAT); chk("R9 status after single", rd_d, stat_val(7, 1, 0));
    wr(A_STAT, 64'h1);
    q = p ^ (64'h1 << 40);
    wr(a_dat(8), p);
    wr(a_chk(8), 64'(enc(q)));
    expect_rd("R7 data bit flip corrected", a_dat(8), q, 1'b1, 1'b0);
    wr(a_dat(10), p);
    wr(a_chk(10), 64'(enc(p) ^ 8'h80));
    expect_rd("R7 parity bit flip", a_dat(10), p, 1'b1, 1'b0);
    wr(A_STAT, 64'h3);
  endtask

  task automatic t_double(input logic [63:0] p);
    wr(a_dat(9), p);
    wr(a_chk(9), 64'(enc(p) ^ 8'h03));
    expect_rd("R8 two check bits", a_dat(9), p, 1'b0, 1'b1);
    rd(A_STAT); chk("R9 status after double", rd_d, stat_val(9, 0, 1));
    wr(a_chk(9), 64'(enc(p ^ (64'h3 << 10))));
    expect_rd("R8 two data bits raw", a_dat(9), p, 1'b0, 1'b1);
    wr(A_STAT, 64'h3);
  endtask

  task automatic t_off(input logic [63:0] p);
    wr(A_CTRL, 64'h35);
    wr(a_dat(11), p);
    wr(a_chk(11), 64'(enc(p) ^ 8'h04));
    expect_rd("R4 single while off", a_dat(11), p, 1'b0, 1'b0);
    wr(a_dat(12), p);
    wr(a_chk(12), 64'(enc(p) ^ 8'h06));
    expect_rd("R4 double while off", a_dat(12), p, 1'b0, 1'b0);
    rd(A_STAT); chk("R4 status untouched", rd_d, stat_val(9, 0, 0));
    chk("R4 irq low", 64'(irq), 64'd0);
  endtask

  task automatic t_irq(input logic [63:0] p);
    wr(A_CTRL, 64'h3A);
    chk("R10 no flag no irq", 64'(irq), 64'd0);
    expect_rd("R7 single while on", a_dat(11), p, 1'b1, 1'b0);
    chk("R10 irq on flag", 64'(irq), 64'd1);
    wr(A_STAT, 64'h1);
    chk("R10 irq cleared", 64'(irq), 64'd0);
    rd(a_dat(11));
    chk("R10 irq again", 64'(irq), 64'd1);
    wr(A_CTRL, 64'h1A);
    chk("R10 irq masked", 64'(irq), 64'd0);
    rd(A_STAT); chk("R9 flag kept while masked", rd_d, stat_val(11, 1, 0));
    wr(A_STAT, 64'h1);
  endtask

  task automatic t_hold();
    rsp_ready = 1'b0;
    rd(a_chk(5));
    chk("R11 held data", rd_d, 64'h0C);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R11 valid held", 64'(rsp_valid), 64'd1);
      chk("R11 data held", rsp_rdata, 64'h0C);
      chk("R11 request stalled", 64'(req_ready), 64'd0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R11 released", 64'({rsp_valid, req_ready}), 64'b01);
  endtask

  initial begin
    logic [63:0] pat;
    begin
      int n;
      n = 0;
      for (int p = 1; p <= 71; p++) if ((p & (p - 1)) != 0) begin posn[n] = p; n++; end
    end
    pat = 64'hA5C3_0F1E_7788_9D42;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_powerup();
    t_zero();
    t_write_off(pat);
    t_keys();
    t_guard(pat);
    t_single(pat);
    t_double(pat);
    t_off(~pat);
    t_irq(~pat);
    t_hold();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule